// File: doc/BRIEF.md
# Eight-bit Accumulator Processor with Hardwired Sequencer

This block is a small 8-bit processor built around a single accumulator. Five registers (program counter, address register, data register, instruction register and accumulator) exchange values over one shared 8-bit internal bus. A 32-word by 8-bit program and data store sits inside the block. A hardwired control unit drives the register loads, the increments and the bus source selects. It is a 4-bit state counter followed by a 4-to-16 state decoder.

Every instruction starts with three fetch states. After the third, the counter jumps straight to an execute entry state taken from the opcode: the entry is the opcode with a zero appended as the low bit. Because of this, each opcode owns two consecutive state slots and uses one or two of them. The last execute state of every instruction clears the counter back to the first fetch state. Software loads the store through a write port, normally while reset is held. The block then runs from address zero, and the program counter and accumulator can be observed at the outputs.

Top module: `acc_cpu`

## Requirements
- R1: A synchronous active-high reset forces program counter, accumulator and all internal registers to zero and the sequencer to its first fetch state. The first instruction after reset is fetched from address 0.
- R2: An instruction word holds the opcode in bits 7..5 and a 5-bit operand address in bits 4..0. Fetch takes three cycles, and the program counter goes up by one per fetched word, wrapping from 31 to 0. In each cycle at most one source drives the internal bus.
- R3: Opcode 110 (load) sets the accumulator to the store word at the operand address. With fetch, the instruction takes 5 cycles.
- R4: Opcode 100 (add) sets the accumulator to the accumulator plus the operand word, modulo 256, in 5 cycles.
- R5: Opcode 011 (subtract) sets the accumulator to the accumulator minus the operand word, modulo 256, in 5 cycles.
- R6: Opcode 010 (exclusive or) sets the accumulator to the accumulator XOR the operand word, in 5 cycles.
- R7: Opcode 111 (increment) adds one to the accumulator modulo 256 and ignores the address field, in 4 cycles.
- R8: Opcode 101 (jump) loads the program counter with the operand address and leaves the accumulator unchanged, in 4 cycles.
- R9: Opcodes 000 and 001 are no-ops. They leave the accumulator unchanged, let the program counter advance by one, and return to fetch after 3 cycles.
- R10: When `pre_we` is high, a rising clock edge writes `pre_data` into the store at `pre_addr`. Instructions then read that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pre_we | input | 1 | Store preload write enable |
| pre_addr | input | 5 | Store preload word address |
| pre_data | input | 8 | Store preload data |
| pc_out | output | 5 | Current program counter |
| ac_out | output | 8 | Current accumulator |

## Verification
A directed program runs every opcode once. Its operands are chosen so that the add wraps past 255, the subtract borrows, and the exclusive or flips all bits. This separates the three ALU select codes and also shows that the increment ignores its address field. A store filled with no-op words checks that fetch takes three cycles per word and that the program counter wraps at 31. A reset pulse in the middle of a run shows that both outputs return to zero. Random stores then run long instruction streams with random jumps, and the program counter and accumulator are compared at every instruction boundary. This boundary is where a wrong per-opcode cycle count, or a wrong execute entry state, would make the observed values drift from the model.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 5;
    localparam int OP_W   = 3;
    localparam int STATE_W = OP_W + 1;

    typedef enum logic [2:0] {
        OP_NOP0 = 3'b000,
        OP_NOP1 = 3'b001,
        OP_XOR  = 3'b010,
        OP_SUB  = 3'b011,
        OP_ADD  = 3'b100,
        OP_JMP  = 3'b101,
        OP_LDA  = 3'b110,
        OP_INC  = 3'b111
    } opcode_e;

    typedef enum logic [1:0] {
        ALU_XOR = 2'b00,
        ALU_SUB = 2'b10,
        ALU_ADD = 2'b11
    } alu_sel_e;

    // Sequencer states: execute entry for an opcode sits at {opcode, 0}
    localparam int ST_FETCH1 = 0;
    localparam int ST_FETCH2 = 1;
    localparam int ST_FETCH3 = 2;
    localparam int ST_XOR1   = 4;
    localparam int ST_XOR2   = 5;
    localparam int ST_SUB1   = 6;
    localparam int ST_SUB2   = 7;
    localparam int ST_ADD1   = 8;
    localparam int ST_ADD2   = 9;
    localparam int ST_JMP1   = 10;
    localparam int ST_LDA1   = 12;
    localparam int ST_LDA2   = 13;
    localparam int ST_INC1   = 14;

    typedef struct packed {
        logic     ar_ld;
        logic     pc_ld;
        logic     pc_inc;
        logic     dr_ld;
        logic     ir_ld;
        logic     ac_ld;
        logic     ac_inc;
        logic     pc_bus;
        logic     dr_bus;
        logic     mem_bus;
        logic     alu_bus;
        alu_sel_e alu_sel;
    } ctrl_t;

    function automatic alu_sel_e alu_sel_of(logic [2:0] op);
        case (op)
            OP_SUB:  return ALU_SUB;
            OP_ADD:  return ALU_ADD;
            default: return ALU_XOR;
        endcase
    endfunction

    function automatic logic is_undefined_op(logic [2:0] op);
        return op[2:1] == 2'b00;
    endfunction

endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
    parameter int DW = acc_cpu_pkg::DATA_W,
    parameter int AW = acc_cpu_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign rdata = words[raddr];

endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
    parameter int DW = acc_cpu_pkg::DATA_W
) (
    input  acc_cpu_pkg::alu_sel_e sel,
    input  logic [DW-1:0]         a,
    input  logic [DW-1:0]         b,
    output logic [DW-1:0]         y
);
    import acc_cpu_pkg::*;

    always_comb begin
        case (sel)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            default: y = a ^ b;
        endcase
    end

endmodule

// File: rtl/acc_seq.sv
module acc_seq #(
    parameter int OPW = acc_cpu_pkg::OP_W,
    parameter int SW  = OPW + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [OPW-1:0]     op_next,
    input  logic [OPW-1:0]     ir_op,
    output acc_cpu_pkg::ctrl_t ctrl,
    output logic [SW-1:0]      state_q
);
    import acc_cpu_pkg::*;

    localparam int NST = 1 << SW;

    logic [NST-1:0] dec;
    logic cnt_clr, cnt_ld, cnt_inc, undef, legal;
    logic f1, f2, f3, x1, x2, s1, s2, a1, a2, j1, l1, l2, i1;

    // state decoder
    for (genvar i = 0; i < NST; i++) begin : g_dec
        assign dec[i] = (state_q == SW'(i));
    end

    assign f1 = dec[ST_FETCH1];
    assign f2 = dec[ST_FETCH2];
    assign f3 = dec[ST_FETCH3];
    assign x1 = dec[ST_XOR1];
    assign x2 = dec[ST_XOR2];
    assign s1 = dec[ST_SUB1];
    assign s2 = dec[ST_SUB2];
    assign a1 = dec[ST_ADD1];
    assign a2 = dec[ST_ADD2];
    assign j1 = dec[ST_JMP1];
    assign l1 = dec[ST_LDA1];
    assign l2 = dec[ST_LDA2];
    assign i1 = dec[ST_INC1];

    assign legal = f1 | f2 | f3 | x1 | x2 | s1 | s2 | a1 | a2 | j1 | l1 | l2 | i1;
    assign undef = f3 & is_undefined_op(op_next);

    always_comb begin
        ctrl         = '0;
        ctrl.pc_bus  = f1;
        ctrl.mem_bus = f2 | x1 | s1 | a1 | l1;
        ctrl.dr_bus  = f3 | j1 | l2;
        ctrl.alu_bus = x2 | s2 | a2;
        ctrl.ar_ld   = f1 | f3;
        ctrl.dr_ld   = f2 | x1 | s1 | a1 | l1;
        ctrl.pc_inc  = f2;
        ctrl.ir_ld   = f3;
        ctrl.pc_ld   = j1;
        ctrl.ac_ld   = x2 | s2 | a2 | l2;
        ctrl.ac_inc  = i1;
        ctrl.alu_sel = alu_sel_of(ir_op);
    end

    // last execute state, undefined opcode, or stray state: back to fetch
    assign cnt_clr = x2 | s2 | a2 | j1 | l2 | i1 | undef | ~legal;
    assign cnt_ld  = f3 & ~undef;
    assign cnt_inc = ~cnt_clr & ~cnt_ld;

    always_ff @(posedge clk) begin
        if (rst || cnt_clr) begin
            state_q <= '0;
        end else if (cnt_ld) begin
            state_q <= {op_next, 1'b0};
        end else if (cnt_inc) begin
            state_q <= state_q + 1'b1;
        end
    end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu #(
    parameter int DW  = acc_cpu_pkg::DATA_W,
    parameter int AW  = acc_cpu_pkg::ADDR_W,
    parameter int OPW = acc_cpu_pkg::OP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [DW-1:0] pre_data,
    output logic [AW-1:0] pc_out,
    output logic [DW-1:0] ac_out
);
    import acc_cpu_pkg::*;

    localparam int SW = OPW + 1;

    ctrl_t          ctrl;
    logic [SW-1:0]  state_q;
    logic [AW-1:0]  pc_q, ar_q;
    logic [DW-1:0]  dr_q, ac_q;
    logic [OPW-1:0] ir_q;
    logic [DW-1:0]  bus, mem_rd, alu_y;
    logic [3:0]     bus_en;

    acc_seq #(.OPW(OPW), .SW(SW)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .op_next (dr_q[DW-1 -: OPW]),
        .ir_op   (ir_q),
        .ctrl    (ctrl),
        .state_q (state_q)
    );

    acc_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (pre_we),
        .waddr (pre_addr),
        .wdata (pre_data),
        .raddr (ar_q),
        .rdata (mem_rd)
    );

    acc_alu #(.DW(DW)) u_alu (
        .sel (ctrl.alu_sel),
        .a   (ac_q),
        .b   (dr_q),
        .y   (alu_y)
    );

    // shared bus: one-hot source enables, OR-combined
    assign bus_en = {ctrl.pc_bus, ctrl.dr_bus, ctrl.mem_bus, ctrl.alu_bus};
    assign bus = ({DW{bus_en[3]}} & {{(DW-AW){1'b0}}, pc_q})
               | ({DW{bus_en[2]}} & dr_q)
               | ({DW{bus_en[1]}} & mem_rd)
               | ({DW{bus_en[0]}} & alu_y);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            ar_q <= '0;
            dr_q <= '0;
            ir_q <= '0;
            ac_q <= '0;
        end else begin
            if (ctrl.ar_ld)       ar_q <= bus[AW-1:0];
            if (ctrl.dr_ld)       dr_q <= bus;
            if (ctrl.ir_ld)       ir_q <= bus[DW-1 -: OPW];
            if (ctrl.pc_ld)       pc_q <= bus[AW-1:0];
            else if (ctrl.pc_inc) pc_q <= pc_q + 1'b1;
            if (ctrl.ac_ld)       ac_q <= bus;
            else if (ctrl.ac_inc) ac_q <= ac_q + 1'b1;
        end
    end

    assign pc_out = pc_q;
    assign ac_out = ac_q;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] state_q,
    input logic [3:0] bus_en,
    input logic [4:0] pc_q,
    input logic [7:0] ac_q,
    input logic [7:0] dr_q
);
    import acc_cpu_pkg::*;

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pc_q == 5'd0 && ac_q == 8'd0 && state_q == 4'(ST_FETCH1))); // R1

    AST_BUS_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bus_en)); // R2

    AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (rst)
        state_q == 4'(ST_FETCH1) |=> state_q == 4'(ST_FETCH2)); // R2

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        state_q == 4'(ST_FETCH2) |=> pc_q == ($past(pc_q) + 5'd1)); // R2

    AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
        state_q == 4'(ST_INC1) |=> ac_q == ($past(ac_q) + 8'd1)); // R7

    AST_JMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        state_q == 4'(ST_JMP1) |=> pc_q == $past(dr_q[4:0])); // R8

    AST_UNDEF_RETURN: assert property (@(posedge clk) disable iff (rst)
        (state_q == 4'(ST_FETCH3) && dr_q[7:6] == 2'b00) |=> state_q == 4'(ST_FETCH1)); // R9

    AST_FETCH_AC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == 4'(ST_FETCH1) || state_q == 4'(ST_FETCH2)) |=> $stable(ac_q)); // R9

endmodule

bind acc_cpu acc_cpu_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .state_q (state_q),
    .bus_en  (bus_en),
    .pc_q    (pc_q),
    .ac_q    (ac_q),
    .dr_q    (dr_q)
);

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pre_we = 1'b0;
    logic [4:0] pre_addr = '0;
    logic [7:0] pre_data = '0;
    logic [4:0] pc_out;
    logic [7:0] ac_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [7:0] img [32];
    logic [4:0] m_pc;
    logic [7:0] m_ac;

    always #4 clk = ~clk;

    acc_cpu u0 (
        .clk      (clk),
        .rst      (rst),
        .pre_we   (pre_we),
        .pre_addr (pre_addr),
        .pre_data (pre_data),
        .pc_out   (pc_out),
        .ac_out   (ac_out)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // reference model: one instruction, returns cycle count and requirement tag
    task automatic model_step(output int cyc, output string tag);
        logic [7:0] w;
        logic [4:0] a;
        w = img[m_pc];
        a = w[4:0];
        m_pc = m_pc + 5'd1;
        case (w[7:5])
            3'b010: begin m_ac = m_ac ^ img[a]; cyc = 5; tag = "R6"; end
            3'b011: begin m_ac = m_ac - img[a]; cyc = 5; tag = "R5"; end
            3'b100: begin m_ac = m_ac + img[a]; cyc = 5; tag = "R4"; end
            3'b101: begin m_pc = a;             cyc = 4; tag = "R8"; end
            3'b110: begin m_ac = img[a];        cyc = 5; tag = "R3/R10"; end
            3'b111: begin m_ac = m_ac + 8'd1;   cyc = 4; tag = "R7"; end
            default: begin                      cyc = 3; tag = "R9"; end
        endcase
    endtask

    // preload the store under reset, check reset state, release
    task automatic load_and_start();
        rst = 1'b1;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            pre_we = 1'b1;
            pre_addr = 5'(i);
            pre_data = img[i];
        end
        @(negedge clk);
        pre_we = 1'b0;
        @(negedge clk);
        check("R1", "pc under reset", int'(pc_out), 0);
        check("R1", "ac under reset", int'(ac_out), 0);
        rst = 1'b0;
        m_pc = '0;
        m_ac = '0;
    endtask

    task automatic run(input int ninst);
        int cyc;
        string tag;
        for (int k = 0; k < ninst; k++) begin
            model_step(cyc, tag);
            repeat (cyc) @(posedge clk);
            @(negedge clk);
            check({"R2/", tag}, "pc", int'(pc_out), int'(m_pc));
            check(tag, "ac", int'(ac_out), int'(m_ac));
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_fails++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));

        // directed: every opcode, wrap/borrow/flip operands
        for (int i = 0; i < 32; i++) img[i] = 8'h00;
        img[0]  = 8'hD4;  // load [20]
        img[1]  = 8'h95;  // add [21]   0xF0+0x20 wraps
        img[2]  = 8'h76;  // sub [22]   borrow
        img[3]  = 8'h57;  // xor [23]   flip all
        img[4]  = 8'hFF;  // inc, address field all ones
        img[5]  = 8'h05;  // no-op 000
        img[6]  = 8'h3A;  // no-op 001
        img[7]  = 8'hA9;  // jump 9
        img[8]  = 8'hFF;  // skipped
        img[9]  = 8'hD8;  // load [24] = 0xFF
        img[10] = 8'hE3;  // inc -> wraps to 0
        img[11] = 8'hA0;  // jump 0
        img[20] = 8'hF0;
        img[21] = 8'h20;
        img[22] = 8'h30;
        img[23] = 8'hFF;
        img[24] = 8'hFF;
        load_and_start();
        run(14);

        // reset in mid-run returns outputs to zero
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1", "pc after mid-run reset", int'(pc_out), 0);
        check("R1", "ac after mid-run reset", int'(ac_out), 0);

        // no-op store: three cycles per word, pc wraps 31 -> 0
        for (int i = 0; i < 32; i++) img[i] = (i % 2 == 0) ? 8'h1F : 8'h20;
        load_and_start();
        run(40);

        // random stores and instruction streams
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < 32; i++) img[i] = 8'($urandom);
            load_and_start();
            run(150);
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule